// File: doc/BRIEF.md
# Reduced-Compliance Boundary-Scan Test Access Port

This block is the test access port of a memory device. A 16-state controller, stepped by the test clock and the mode-select input, sequences a 3-bit instruction register and three data registers. The data registers are a 32-bit identification register, a 1-bit bypass register and a capture-only boundary register. The boundary register takes a parallel snapshot of the device's pins on `pin_snap` and shifts it out serially. The block also drives `out_hiz`, which forces the device's data outputs to high impedance.

Full boundary-scan compliance is intentionally not provided. Scan data is never driven onto device pins, so Update-DR does nothing. The all-zeros instruction captures the pins the same way the sample instruction does, and it also floats the outputs. An extra instruction samples the pins while holding the outputs floated. The identification instruction is active after any reset. Reserved codes fall back to the bypass register and have no other effect.

Top module: `scan_tap`

## Requirements
- R1: While `trst_n` is low, the controller is held in Test-Logic-Reset, the active instruction is identification (001), `out_hiz` is 0 and `tdo_en` is 0. After release, a data scan with no instruction load shifts out the identification value.
- R2: Five consecutive TCK rising edges with `tms` high reach Test-Logic-Reset from any state. The edge that enters Test-Logic-Reset makes identification (001) the active instruction.
- R3: Capture-IR loads 3'b001 into the instruction shift register. Instruction bits shift LSB first from `tdi` toward `tdo`. A shifted code becomes active only on the rising edge that leaves Update-IR, and `out_hiz` does not change before that edge.
- R4: Code 001 selects the 32-bit identification register. The register loads `ID_VALUE` in Capture-DR and shifts it out LSB first, followed by `tdi` delayed by 32 cycles.
- R5: Code 000 selects the boundary register, which captures `pin_snap` in Capture-DR. `out_hiz` is 1 while this code is active.
- R6: Code 010 selects the boundary register in the same way. `out_hiz` is 1 while this code is active.
- R7: Code 100 captures `pin_snap` into the boundary register in Capture-DR. The snapshot shifts out LSB first, followed by `tdi` delayed by `BSR_W` cycles. `out_hiz` is 0.
- R8: Passing through Update-DR changes neither the active instruction nor `out_hiz`. A later data scan still selects the same register.
- R9: Code 111 selects the bypass register. The register captures 0, then passes `tdi` to `tdo` with one cycle of delay.
- R10: Reserved codes 011, 101 and 110 behave like bypass and leave `out_hiz` at 0.
- R11: `tdo` and `tdo_en` update on the falling edge of TCK. `tdo_en` is 1 only in the half cycle that follows a rising edge landing in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| pin_snap | input | BSR_W | Parallel pin values for the boundary capture |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | Output enable for tdo |
| out_hiz | output | 1 | Forces device data outputs to high impedance |

## Verification
The controller state and all shift registers advance on rising TCK. `tdo` and `tdo_en` follow on the next falling edge. The bench therefore changes inputs shortly after a falling edge and reads `tdo` only after the next falling edge has passed. The first captured bit appears in the half cycle after the edge that enters Shift-DR or Shift-IR. The instruction, and with it `out_hiz`, changes on the edge that leaves Update-IR, so the bench reads `out_hiz` once while still in Exit1-IR and again after that edge. The asynchronous reset is checked 1 ns after `trst_n` falls, with no clock edge in between.

// File: rtl/scan_tap.sv
module scan_tap #(
  parameter int          BSR_W    = 8,
  parameter logic [31:0] ID_VALUE = 32'h1A5C_0F3B
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  input  logic [BSR_W-1:0] pin_snap,
  output logic             tdo,
  output logic             tdo_en,
  output logic             out_hiz
);
  localparam logic [3:0] S_TLR = 4'd0, S_RTI = 4'd1, S_SDR = 4'd2, S_CDR = 4'd3,
                         S_SHDR = 4'd4, S_E1DR = 4'd5, S_PDR = 4'd6, S_E2DR = 4'd7,
                         S_UDR = 4'd8, S_SIR = 4'd9, S_CIR = 4'd10, S_SHIR = 4'd11,
                         S_E1IR = 4'd12, S_PIR = 4'd13, S_E2IR = 4'd14, S_UIR = 4'd15;
  localparam logic [2:0] I_EXT = 3'b000, I_ID = 3'b001, I_SZ = 3'b010, I_SMP = 3'b100;

  logic [3:0]       state, nxt;
  logic [2:0]       ir, ir_sh;
  logic [31:0]      id_sh;
  logic [BSR_W-1:0] bsr_sh;
  logic             byp, tdo_q, en_q;

  wire sel_id  = (ir == I_ID);
  wire sel_bsr = (ir == I_EXT) || (ir == I_SZ) || (ir == I_SMP);
  wire dr_out  = sel_id ? id_sh[0] : (sel_bsr ? bsr_sh[0] : byp);

  always_comb begin
    unique case (state)
      S_TLR:  nxt = tms ? S_TLR  : S_RTI;
      S_RTI:  nxt = tms ? S_SDR  : S_RTI;
      S_SDR:  nxt = tms ? S_SIR  : S_CDR;
      S_CDR:  nxt = tms ? S_E1DR : S_SHDR;
      S_SHDR: nxt = tms ? S_E1DR : S_SHDR;
      S_E1DR: nxt = tms ? S_UDR  : S_PDR;
      S_PDR:  nxt = tms ? S_E2DR : S_PDR;
      S_E2DR: nxt = tms ? S_UDR  : S_SHDR;
      S_UDR:  nxt = tms ? S_SDR  : S_RTI;
      S_SIR:  nxt = tms ? S_TLR  : S_CIR;
      S_CIR:  nxt = tms ? S_E1IR : S_SHIR;
      S_SHIR: nxt = tms ? S_E1IR : S_SHIR;
      S_E1IR: nxt = tms ? S_UIR  : S_PIR;
      S_PIR:  nxt = tms ? S_E2IR : S_PIR;
      S_E2IR: nxt = tms ? S_UIR  : S_SHIR;
      default: nxt = tms ? S_SDR : S_RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state  <= S_TLR;
      ir     <= I_ID;
      ir_sh  <= 3'b001;
      id_sh  <= '0;
      bsr_sh <= '0;
      byp    <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt == S_TLR)       ir <= I_ID;
      else if (state == S_UIR) ir <= ir_sh;
      if (state == S_CIR)       ir_sh <= 3'b001;
      else if (state == S_SHIR) ir_sh <= {tdi, ir_sh[2:1]};
      if (state == S_CDR) begin
        if (sel_id)       id_sh  <= ID_VALUE;
        else if (sel_bsr) bsr_sh <= pin_snap;
        else              byp    <= 1'b0;
      end else if (state == S_SHDR) begin
        if (sel_id)       id_sh  <= {tdi, id_sh[31:1]};
        else if (sel_bsr) bsr_sh <= {tdi, bsr_sh[BSR_W-1:1]};
        else              byp    <= tdi;
      end
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      tdo_q <= (state == S_SHIR) ? ir_sh[0] : dr_out;
      en_q  <= (state == S_SHIR) || (state == S_SHDR);
    end
  end

  assign tdo     = tdo_q;
  assign tdo_en  = en_q;
  assign out_hiz = (ir == I_EXT) || (ir == I_SZ);
endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk (
  input logic       tck,
  input logic       trst_n,
  input logic       tms,
  input logic [3:0] state,
  input logic [2:0] ir,
  input logic [2:0] ir_sh,
  input logic       byp,
  input logic       tdo_en,
  input logic       out_hiz
);
  localparam logic [3:0] S_TLR = 4'd0, S_CDR = 4'd3, S_SHDR = 4'd4, S_UDR = 4'd8,
                         S_CIR = 4'd10, S_SHIR = 4'd11, S_UIR = 4'd15;

  logic [2:0] hi_cnt;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     hi_cnt <= '0;
    else if (!tms)   hi_cnt <= '0;
    else if (hi_cnt != 3'd7) hi_cnt <= hi_cnt + 3'd1;
  end

  assert_five_tms_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (hi_cnt >= 3'd5) |-> (state == S_TLR));
  assert_tlr_idcode_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_TLR) |-> (ir == 3'b001));
  assert_ir_change_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (ir != $past(ir)) |-> ($past(state) == S_UIR || state == S_TLR));
  assert_capture_ir_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_CIR) |=> (ir_sh == 3'b001));
  assert_update_dr_R8: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_UDR) |=> ($stable(ir) && $stable(out_hiz)));
  assert_bypass_zero_R9: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_CDR && ir == 3'b111) |=> (byp == 1'b0));
  assert_tdo_en_shift_R11: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (state == S_SHIR || state == S_SHDR));
endmodule

bind scan_tap scan_tap_chk chk_i (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .ir(ir),
  .ir_sh(ir_sh), .byp(byp), .tdo_en(tdo_en), .out_hiz(out_hiz)
);

// File: tb/scan_tap_tb.sv
module scan_tap_tb_top;
  localparam int          BSR_W = 8;
  localparam logic [31:0] IDV   = 32'h1A5C_0F3B;
  localparam int          NB    = 48;
  localparam logic [63:0] DIN   = 64'hC3A5_96E1_7B2D_480F;
  // {code[2:0], expected out_hiz, register kind: 0 bypass, 1 id, 2 boundary}
  localparam logic [5:0] VEC [8] = '{
    {3'b000, 1'b1, 2'd2}, {3'b001, 1'b0, 2'd1}, {3'b010, 1'b1, 2'd2}, {3'b011, 1'b0, 2'd0},
    {3'b100, 1'b0, 2'd2}, {3'b101, 1'b0, 2'd0}, {3'b110, 1'b0, 2'd0}, {3'b111, 1'b0, 2'd0}};

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [BSR_W-1:0] snap = 8'h00;
  logic tdo, tdo_en, out_hiz;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  scan_tap #(.BSR_W(BSR_W), .ID_VALUE(IDV)) dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_snap(snap),
    .tdo(tdo), .tdo_en(tdo_en), .out_hiz(out_hiz));

  always #10 tck = ~tck;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clk(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #2;
  endtask

  task automatic ir_scan(input logic [2:0] code, output logic [2:0] cap, output logic hiz_mid);
    clk(1, 0); clk(1, 0); clk(0, 0); clk(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      clk(i == 2, code[i]);
    end
    hiz_mid = out_hiz;
    clk(1, 0); clk(0, 0);
  endtask

  task automatic dr_scan(output logic [63:0] dout, output logic en_ok);
    dout = '0; en_ok = 1'b1;
    clk(1, 0); clk(0, 0); clk(0, 0);
    for (int i = 0; i < NB; i++) begin
      dout[i] = tdo;
      if (tdo_en !== 1'b1) en_ok = 1'b0;
      clk(i == NB - 1, DIN[i]);
    end
    clk(1, 0); clk(0, 0);
  endtask

  function automatic logic [63:0] expect_dr(input logic [1:0] kind, input logic [BSR_W-1:0] s);
    int len;
    logic [63:0] cap, r;
    len = (kind == 2'd1) ? 32 : (kind == 2'd2) ? BSR_W : 1;
    cap = (kind == 2'd1) ? {32'h0, IDV} : (kind == 2'd2) ? {{(64-BSR_W){1'b0}}, s} : 64'h0;
    r = '0;
    for (int i = 0; i < NB; i++) r[i] = (i < len) ? cap[i] : DIN[i-len];
    return r;
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] dout;
    logic [2:0] cap;
    logic hiz_mid, en_ok, prev_hiz;
    #25;
    check("R1 out_hiz in reset", {63'h0, out_hiz}, 64'h0);
    check("R1 tdo_en in reset", {63'h0, tdo_en}, 64'h0);
    @(negedge tck); #2; trst_n = 1'b1;
    clk(0, 0);
    check("R11 tdo_en idle", {63'h0, tdo_en}, 64'h0);
    dr_scan(dout, en_ok);
    check("R1 default idcode scan", dout, expect_dr(2'd1, snap));

    prev_hiz = 1'b0;
    for (int v = 0; v < 8; v++) begin
      logic [2:0] code;
      code = VEC[v][5:3];
      snap = 8'h3C + 8'(code) * 8'd37;
      ir_scan(code, cap, hiz_mid);
      check("R3 capture-ir pattern", {61'h0, cap}, 64'h1);
      check("R3 out_hiz held before update-ir", {63'h0, hiz_mid}, {63'h0, prev_hiz});
      check(code == 3'b000 ? "R5 out_hiz" : code == 3'b010 ? "R6 out_hiz" :
            code == 3'b100 ? "R7 out_hiz" : "R10 out_hiz", {63'h0, out_hiz}, {63'h0, VEC[v][2]});
      dr_scan(dout, en_ok);
      check(code == 3'b000 ? "R5 boundary scan" : code == 3'b001 ? "R4 id scan" :
            code == 3'b010 ? "R6 boundary scan" : code == 3'b100 ? "R7 sample scan" :
            code == 3'b111 ? "R9 bypass scan" : "R10 reserved bypass", dout, expect_dr(VEC[v][1:0], snap));
      check("R11 tdo_en during shift", {63'h0, en_ok}, 64'h1);
      check("R11 tdo_en after scan", {63'h0, tdo_en}, 64'h0);
      check("R8 out_hiz after update-dr", {63'h0, out_hiz}, {63'h0, VEC[v][2]});
      snap = ~snap;
      dr_scan(dout, en_ok);
      check("R8 same register after update-dr", dout, expect_dr(VEC[v][1:0], snap));
      prev_hiz = VEC[v][2];
    end

    ir_scan(3'b000, cap, hiz_mid);
    check("R5 extest loaded", {63'h0, out_hiz}, 64'h1);
    clk(1, 0); clk(0, 0); clk(0, 0);
    for (int k = 0; k < 5; k++) clk(1, 0);
    check("R2 five tms high resets instruction", {63'h0, out_hiz}, 64'h0);
    clk(0, 0);
    dr_scan(dout, en_ok);
    check("R2 idcode after tms reset", dout, expect_dr(2'd1, snap));

    ir_scan(3'b010, cap, hiz_mid);
    check("R6 sample-z loaded", {63'h0, out_hiz}, 64'h1);
    #3; trst_n = 1'b0; #1;
    check("R1 async reset clears out_hiz", {63'h0, out_hiz}, 64'h0);
    check("R1 async reset clears tdo_en", {63'h0, tdo_en}, 64'h0);
    @(negedge tck); #2; trst_n = 1'b1;
    clk(0, 0);
    dr_scan(dout, en_ok);
    check("R1 idcode after async reset", dout, expect_dr(2'd1, snap));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule